// File: doc/BRIEF.md
# Remote-Control Frame Receive Decoder

This block sits behind the pulse classifier of an infrared remote-control receiver. Each cycle it may get a one-cycle symbol strobe with a code naming the pulse just seen: header, data 0, data 1, special data or frame end. It turns that stream into a frame. Data bits go into a 48-bit receive buffer, and six sticky status flags are kept, with a received-bit count beside them. Pulse-width measurement happens upstream and is not part of this block.

Three configuration inputs set the behaviour. Header enable makes the decoder insist on a header before it takes any data. Special-data enable lets the special symbol be recognised. The two modes exclude each other: each one counts only while the other is off. Error hold decides whether the receive-error flag stays set until the flag-clear input is pulsed, or clears on the next accepted data bit. A parameter builds either the full channel or the reduced one. The reduced channel has no buffer storage and ignores error hold.

The controller has three states. IDLE waits for a frame. HUNT waits for a header. DATA accepts bits. The transitions are:
- IDLE→HUNT on the first strobe when header mode is on.
- IDLE→DATA on the first strobe when header mode is off. In both cases that first symbol is also processed in the state entered.
- HUNT→DATA on a header.
- HUNT→HUNT on data or special symbols, which raise an error.
- HUNT→IDLE and DATA→IDLE on frame end.
- DATA→DATA on a header in header mode, which restarts the count.

Top module: `rcd_frame_rx`

## Requirements
- R1: After reset all six flags, the buffer and the bit count are 0, and the decoder is in IDLE.
- R2: In IDLE, a recognised strobe (codes 0 to 4) sets the started flag and resets the bit count to 0 (a new frame), and is then processed as a symbol.
- R3: Codes are header=0, data0=1, data1=2, special=3, frame end=4. In HUNT, a data0, data1 or special symbol sets the receive-error flag and leaves the data-0, data-1 and special flags, the buffer and the bit count unchanged.
- R4: In HUNT, a header sets the header flag, resets the bit count to 0 and enters DATA. In DATA with header mode on, a header sets the header flag and resets the count again.
- R5: In DATA, data1 writes 1 and data0 writes 0 into buffer bit index equal to the count (bit 0 of byte 0 first). The count then steps by one and wraps from 47 to 0, so the 49th bit overwrites bit 0.
- R6: An accepted data0 sets the data-0 flag and clears the data-1 flag. An accepted data1 does the opposite.
- R7: Header mode is header enable AND NOT special enable. Special mode is special enable AND NOT header enable. A special symbol in DATA sets the special flag only in special mode. With both enables set, no header is required and special symbols are ignored.
- R8: With error hold off, an accepted data bit clears the receive-error flag. With error hold on, the flag stays set until flag clear.
- R9: Frame end returns the decoder to IDLE. When header mode is on, the next frame again needs a header.
- R10: Flag clear zeroes all six flags. An event in the same cycle is applied after the clear and wins.
- R11: In the reduced channel (FULL_CH=0) the buffer output stays 0 and error hold has no effect. Flags and count behave as in the full channel.
- R12: A strobe with code 5, 6 or 7, or no strobe, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sym_valid | input | 1 | One-cycle symbol strobe |
| sym_code | input | 3 | Symbol code (0 header, 1 data0, 2 data1, 3 special, 4 frame end) |
| hdr_en | input | 1 | Header-required mode enable |
| spc_en | input | 1 | Special-data mode enable |
| err_hold | input | 1 | Keep receive error until explicit clear |
| flag_clr | input | 1 | Clear all six status flags |
| started | output | 1 | Reception started flag |
| hdr_seen | output | 1 | Header detected flag |
| d0_seen | output | 1 | Last data bit was 0 |
| d1_seen | output | 1 | Last data bit was 1 |
| spc_seen | output | 1 | Special data detected flag |
| rx_err | output | 1 | Receive error flag |
| rx_buf | output | BUF_BITS | Receive data buffer |
| bit_cnt | output | CNT_W | Received-bit count / next write index |

## Verification
On every cycle the assertions check four things:
- A pre-header error never moves the data-0, data-1 or special flags.
- The buffer changes only on an accepted bit, and that bit lands at the index it was given.
- The count stays below 48, the two data flags are never both set, and a held error survives without a clear.
- Header and special acceptance each require the other mode to be off.

Other behaviours show only in the bench's scenarios, which compare against a reference model:
- the wrap that overwrites bit 0 after 48 bits;
- the need for a new header after frame end;
- the precedence of an event over a simultaneous clear;
- the reduced channel ignoring error hold.

// File: rtl/rcd_pkg.sv
package rcd_pkg;

    // Symbol codes delivered by the upstream pulse classifier.
    typedef enum logic [2:0] {
        SYM_HDR = 3'd0,
        SYM_D0  = 3'd1,
        SYM_D1  = 3'd2,
        SYM_SPC = 3'd3,
        SYM_END = 3'd4
    } sym_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HUNT = 2'd1,
        ST_DATA = 2'd2
    } rx_state_e;

    // One-cycle decode events handed from the controller to flags and buffer.
    typedef struct packed {
        logic new_frame;
        logic acc_hdr;
        logic acc_bit;
        logic bit_val;
        logic acc_spc;
        logic pre_err;
    } rx_evt_t;

endpackage

// File: rtl/rcd_fsm.sv
module rcd_fsm
    import rcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sym_valid,
    input  logic [2:0] sym_code,
    input  logic       hdr_en,
    input  logic       spc_en,
    output rx_evt_t    evt
);

    rx_state_e state, eff, nxt;
    logic      known, hdr_mode, spc_mode;

    assign known    = sym_valid && (sym_code <= SYM_END);
    assign hdr_mode = hdr_en & ~spc_en;
    assign spc_mode = spc_en & ~hdr_en;

    // Effective state: a strobe in IDLE opens a frame and is handled at once
    always_comb begin
        eff = state;
        if (known && state == ST_IDLE)
            eff = hdr_mode ? ST_HUNT : ST_DATA;
    end

    // Next-state logic
    always_comb begin
        nxt = eff;
        if (known) begin
            unique case (eff)
                ST_IDLE: nxt = ST_IDLE;
                ST_HUNT: begin
                    if (sym_code == SYM_HDR)      nxt = ST_DATA;
                    else if (sym_code == SYM_END) nxt = ST_IDLE;
                    else                          nxt = ST_HUNT;
                end
                ST_DATA: begin
                    if (sym_code == SYM_END) nxt = ST_IDLE;
                    else                     nxt = ST_DATA;
                end
                default: nxt = ST_IDLE;
            endcase
        end else begin
            nxt = state;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Event outputs
    always_comb begin
        evt = '0;
        if (known) begin
            evt.new_frame = (state == ST_IDLE);
            unique case (eff)
                ST_IDLE: ;
                ST_HUNT: begin
                    unique case (sym_code)
                        SYM_HDR: evt.acc_hdr = 1'b1;
                        SYM_D0, SYM_D1, SYM_SPC: evt.pre_err = 1'b1;
                        default: ;
                    endcase
                end
                ST_DATA: begin
                    unique case (sym_code)
                        SYM_HDR: evt.acc_hdr = hdr_mode;
                        SYM_D0: evt.acc_bit = 1'b1;
                        SYM_D1: begin
                            evt.acc_bit = 1'b1;
                            evt.bit_val = 1'b1;
                        end
                        SYM_SPC: evt.acc_spc = spc_mode;
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    // R7: header acceptance only with special mode off
    assert_hdr_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.acc_hdr && state == ST_DATA) |-> !spc_en);
    // R7: special acceptance only with header mode off
    assert_spc_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        evt.acc_spc |-> !hdr_en);
    // R9: frame end always lands in IDLE
    assert_end_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (known && sym_code == SYM_END) |=> state == ST_IDLE);

endmodule

// File: rtl/rcd_flags.sv
module rcd_flags
    import rcd_pkg::*;
#(
    parameter bit HOLD_OK = 1'b1
) (
    input  logic    clk,
    input  logic    rst_n,
    input  rx_evt_t evt,
    input  logic    err_hold,
    input  logic    flag_clr,
    output logic    started,
    output logic    hdr_seen,
    output logic    d0_seen,
    output logic    d1_seen,
    output logic    spc_seen,
    output logic    rx_err
);

    typedef struct packed {
        logic st, hd, d0, d1, sp, er;
    } flag_t;

    flag_t cur, nxt;
    logic  hold_eff;

    generate
        if (HOLD_OK) begin : g_hold
            assign hold_eff = err_hold;
        end else begin : g_nohold
            logic unused_hold;
            assign unused_hold = err_hold;
            assign hold_eff    = 1'b0;
        end
    endgenerate

    // Clear first, then this cycle's events take precedence
    always_comb begin
        nxt = flag_clr ? '0 : cur;
        if (evt.new_frame) nxt.st = 1'b1;
        if (evt.acc_hdr)   nxt.hd = 1'b1;
        if (evt.acc_spc)   nxt.sp = 1'b1;
        if (evt.pre_err)   nxt.er = 1'b1;
        if (evt.acc_bit) begin
            nxt.d0 = ~evt.bit_val;
            nxt.d1 = evt.bit_val;
            if (!hold_eff) nxt.er = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur <= '0;
        else        cur <= nxt;
    end

    assign started  = cur.st;
    assign hdr_seen = cur.hd;
    assign d0_seen  = cur.d0;
    assign d1_seen  = cur.d1;
    assign spc_seen = cur.sp;
    assign rx_err   = cur.er;

    // R3: a pre-header error leaves the data and special flags alone
    assert_pre_err_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.pre_err && !flag_clr) |=> ($stable(d0_seen) && $stable(d1_seen) && $stable(spc_seen)));
    // R6: the two data flags never both set
    assert_data_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({d0_seen, d1_seen}));
    // R8: held error survives until explicit clear
    assert_err_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (HOLD_OK && err_hold && rx_err && !flag_clr) |=> rx_err);

endmodule

// File: rtl/rcd_rxbuf.sv
module rcd_rxbuf #(
    parameter int BUF_BITS = 48,
    parameter bit STORE    = 1'b1,
    localparam int CNT_W   = $clog2(BUF_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                restart,
    input  logic                wr_en,
    input  logic                wr_bit,
    output logic [BUF_BITS-1:0] buf_q,
    output logic [CNT_W-1:0]    cnt
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(BUF_BITS - 1);

    logic [CNT_W-1:0] idx;

    // A restart in the same cycle as a bit places that bit at index 0
    assign idx = restart ? '0 : cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (wr_en)
            cnt <= (idx == LAST) ? '0 : idx + 1'b1;
        else if (restart)
            cnt <= '0;
    end

    generate
        if (STORE) begin : g_store
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)     buf_q <= '0;
                else if (wr_en) buf_q[idx] <= wr_bit;
            end
            // R3: buffer changes only on an accepted data bit
            assert_no_stray_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
                !wr_en |=> $stable(buf_q));
            // R5: the accepted bit lands at its index
            assert_bit_placed_R5: assert property (@(posedge clk) disable iff (!rst_n)
                wr_en |=> buf_q[$past(idx)] == $past(wr_bit));
        end else begin : g_nostore
            logic unused_bit;
            assign unused_bit = wr_bit;
            assign buf_q      = '0;
        end
    endgenerate

    // R5: count stays within the buffer
    assert_cnt_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

endmodule

// File: rtl/rcd_frame_rx.sv
module rcd_frame_rx
    import rcd_pkg::*;
#(
    parameter int BUF_BITS = 48,
    parameter bit FULL_CH  = 1'b1,
    localparam int CNT_W   = $clog2(BUF_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sym_valid,
    input  logic [2:0]          sym_code,
    input  logic                hdr_en,
    input  logic                spc_en,
    input  logic                err_hold,
    input  logic                flag_clr,
    output logic                started,
    output logic                hdr_seen,
    output logic                d0_seen,
    output logic                d1_seen,
    output logic                spc_seen,
    output logic                rx_err,
    output logic [BUF_BITS-1:0] rx_buf,
    output logic [CNT_W-1:0]    bit_cnt
);

    rx_evt_t evt;

    rcd_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sym_valid (sym_valid),
        .sym_code  (sym_code),
        .hdr_en    (hdr_en),
        .spc_en    (spc_en),
        .evt       (evt)
    );

    rcd_flags #(.HOLD_OK(FULL_CH)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .err_hold (err_hold),
        .flag_clr (flag_clr),
        .started  (started),
        .hdr_seen (hdr_seen),
        .d0_seen  (d0_seen),
        .d1_seen  (d1_seen),
        .spc_seen (spc_seen),
        .rx_err   (rx_err)
    );

    rcd_rxbuf #(.BUF_BITS(BUF_BITS), .STORE(FULL_CH)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (evt.new_frame | evt.acc_hdr),
        .wr_en   (evt.acc_bit),
        .wr_bit  (evt.bit_val),
        .buf_q   (rx_buf),
        .cnt     (bit_cnt)
    );

endmodule

// File: tb/rcd_frame_rx_test.sv
module rcd_frame_rx_test;

    localparam int CLK_PERIOD = 10;
    localparam int NB = 48;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sym_valid = 1'b0;
    logic [2:0] sym_code = 3'd0;
    logic       hdr_en = 1'b0, spc_en = 1'b0, err_hold = 1'b0, flag_clr = 1'b0;

    logic a_st, a_hd, a_d0, a_d1, a_sp, a_er;
    logic b_st, b_hd, b_d0, b_d1, b_sp, b_er;
    logic [NB-1:0] a_buf, b_buf;
    logic [5:0]    a_cnt, b_cnt;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rcd_frame_rx uut (
        .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_code(sym_code),
        .hdr_en(hdr_en), .spc_en(spc_en), .err_hold(err_hold), .flag_clr(flag_clr),
        .started(a_st), .hdr_seen(a_hd), .d0_seen(a_d0), .d1_seen(a_d1),
        .spc_seen(a_sp), .rx_err(a_er), .rx_buf(a_buf), .bit_cnt(a_cnt));

    rcd_frame_rx #(.FULL_CH(1'b0)) uut_b (
        .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_code(sym_code),
        .hdr_en(hdr_en), .spc_en(spc_en), .err_hold(err_hold), .flag_clr(flag_clr),
        .started(b_st), .hdr_seen(b_hd), .d0_seen(b_d0), .d1_seen(b_d1),
        .spc_seen(b_sp), .rx_err(b_er), .rx_buf(b_buf), .bit_cnt(b_cnt));

    // Reference model, one slot per channel (0 full, 1 reduced)
    int            m_st[2];
    logic          m_f[2][6];   // started, header, d0, d1, special, error
    logic [NB-1:0] m_buf[2];
    int            m_cnt[2];

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            m_st[c] = 0; m_buf[c] = '0; m_cnt[c] = 0;
            for (int k = 0; k < 6; k++) m_f[c][k] = 1'b0;
        end
    endtask

    task automatic model_step(input int c);
        bit known, hm, sm, nf, hold;
        int eff, code;
        code  = int'(sym_code);
        known = sym_valid && code <= 4;
        hm    = hdr_en && !spc_en;
        sm    = spc_en && !hdr_en;
        hold  = (c == 0) && err_hold;
        nf    = 0;
        if (flag_clr) for (int k = 0; k < 6; k++) m_f[c][k] = 1'b0;
        if (!known) return;
        eff = m_st[c];
        if (eff == 0) begin
            nf = 1; eff = hm ? 1 : 2; m_f[c][0] = 1'b1; m_cnt[c] = 0;
        end
        m_st[c] = eff;
        if (eff == 1) begin
            if (code == 0) begin m_f[c][1] = 1'b1; m_cnt[c] = 0; m_st[c] = 2; end
            else if (code == 4) m_st[c] = 0;
            else m_f[c][5] = 1'b1;
        end else begin
            if (code == 0 && hm) begin m_f[c][1] = 1'b1; m_cnt[c] = 0; end
            else if (code == 1 || code == 2) begin
                if (c == 0) m_buf[c][m_cnt[c]] = (code == 2);
                m_cnt[c] = (m_cnt[c] == NB-1) ? 0 : m_cnt[c] + 1;
                m_f[c][2] = (code == 1); m_f[c][3] = (code == 2);
                if (!hold) m_f[c][5] = 1'b0;
            end
            else if (code == 3 && sm) m_f[c][4] = 1'b1;
            else if (code == 4) m_st[c] = 0;
        end
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R2 started A",  64'(a_st), 64'(m_f[0][0]));
        chk("R4 header A",   64'(a_hd), 64'(m_f[0][1]));
        chk("R6 d0 A",       64'(a_d0), 64'(m_f[0][2]));
        chk("R6 d1 A",       64'(a_d1), 64'(m_f[0][3]));
        chk("R7 special A",  64'(a_sp), 64'(m_f[0][4]));
        chk("R8 error A",    64'(a_er), 64'(m_f[0][5]));
        chk("R5 buffer A",   64'(a_buf), 64'(m_buf[0]));
        chk("R5 count A",    64'(a_cnt), 64'(m_cnt[0]));
        chk("R11 started B", 64'(b_st), 64'(m_f[1][0]));
        chk("R11 header B",  64'(b_hd), 64'(m_f[1][1]));
        chk("R11 d0 B",      64'(b_d0), 64'(m_f[1][2]));
        chk("R11 d1 B",      64'(b_d1), 64'(m_f[1][3]));
        chk("R11 special B", 64'(b_sp), 64'(m_f[1][4]));
        chk("R11 error B",   64'(b_er), 64'(m_f[1][5]));
        chk("R11 buffer B",  64'(b_buf), 64'(m_buf[1]));
        chk("R11 count B",   64'(b_cnt), 64'(m_cnt[1]));
    endtask

    task automatic step(input logic v, input logic [2:0] c, input logic clr);
        @(negedge clk);
        sym_valid = v; sym_code = c; flag_clr = clr;
        @(posedge clk); #1;
        model_step(0); model_step(1);
        compare_all();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        model_reset();
        #(CLK_PERIOD * 3);
        #1; compare_all();                          // R1 during reset
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 reset count", 64'(a_cnt), 64'd0);
        chk("R1 reset buffer", 64'(a_buf), 64'd0);
        compare_all();

        // R12: unknown codes do not open a frame
        step(1'b1, 3'd6, 1'b0);
        chk("R12 unknown code started", 64'(a_st), 64'd0);

        // R3: data before header in header mode
        hdr_en = 1; spc_en = 0; err_hold = 0;
        step(1'b1, 3'd2, 1'b0);
        chk("R2 started on first strobe", 64'(a_st), 64'd1);
        chk("R3 pre-header error", 64'(a_er), 64'd1);
        chk("R3 d1 untouched", 64'(a_d1), 64'd0);
        chk("R3 buffer untouched", 64'(a_buf), 64'd0);

        // R4, R5: header then 50 bits, wrap overwrites bit 0
        step(1'b1, 3'd0, 1'b0);
        chk("R4 header seen", 64'(a_hd), 64'd1);
        for (int i = 0; i < 50; i++) step(1'b1, (i == 48) ? 3'd2 : 3'd1, 1'b0);
        chk("R5 wrap count", 64'(a_cnt), 64'd2);
        chk("R5 wrap bit0 overwritten", 64'(a_buf[0]), 64'd1);
        chk("R8 error cleared by data (hold off)", 64'(a_er), 64'd0);
        chk("R6 last bit was 0", 64'({a_d0, a_d1}), 64'b10);

        // R9: frame end then data needs header again
        step(1'b1, 3'd4, 1'b0);
        step(1'b1, 3'd1, 1'b0);
        chk("R9 header needed after end", 64'(a_er), 64'd1);

        // R8, R11: hold keeps error in full channel only
        err_hold = 1;
        step(1'b1, 3'd0, 1'b0);
        step(1'b1, 3'd2, 1'b0);
        chk("R8 held error", 64'(a_er), 64'd1);
        chk("R11 reduced ignores hold", 64'(b_er), 64'd0);
        chk("R11 reduced buffer zero", 64'(b_buf), 64'd0);

        // R10: clear with simultaneous data bit
        step(1'b1, 3'd1, 1'b1);
        chk("R10 clear drops error", 64'(a_er), 64'd0);
        chk("R10 event wins over clear", 64'(a_d0), 64'd1);
        chk("R10 header cleared", 64'(a_hd), 64'd0);

        // R7: both enables set -> no header needed, special ignored
        err_hold = 0; hdr_en = 1; spc_en = 1;
        step(1'b1, 3'd4, 1'b0);
        step(1'b1, 3'd3, 1'b0);
        chk("R7 special ignored with both", 64'(a_sp), 64'd0);
        step(1'b1, 3'd2, 1'b0);
        chk("R7 data taken without header", 64'(a_cnt), 64'd1);
        hdr_en = 0;
        step(1'b1, 3'd3, 1'b0);
        chk("R7 special in special mode", 64'(a_sp), 64'd1);

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            if (($urandom % 64) == 0) begin
                hdr_en = $urandom % 2; spc_en = $urandom % 2; err_hold = $urandom % 2;
            end
            step(($urandom % 4) != 0, 3'($urandom % 8), ($urandom % 40) == 0);
        end
        step(1'b0, 3'd0, 1'b0);
        finish_run();
    end

endmodule